// File: doc/BRIEF.md
# Multi-Lane Shift-Register Random Word Generator

This block produces a pseudo-random word of `N_LANES` bits. Inside are `N_LANES` separate maximal-length shift-register generators (lanes), each `LFSR_W` bits wide, with XNOR feedback. One lane gives only one fresh bit per clock, because its other register bits are delayed copies of earlier fresh bits. So in parallel mode the block takes one fresh bit from each lane and forms a whole new word on every enabled clock. A host that needs the output of a single generator can use serial mode. In that mode the fresh bit of lane 0 enters the top of the word and the older bits move toward bit 0. Putting the new bit in at the top stops the output from climbing as a noisy ramp that wraps into a sawtooth.

One external value, for example a real-time clock count taken at start-up, seeds all lanes at once. Each lane mixes this value with its own constant, so the lanes begin at well-separated points. With XNOR feedback the all-ones state can never be left. A mixed seed that would land there is replaced by a legal constant before it is loaded.

Top module: `rng_word_gen`

## Requirements
- R1: Each lane steps as next = {s[W-2:0], f}, where f is the XNOR of the tap bits. For the default W=16 the taps are bits 15, 14, 12 and 3, so f = ~(s[15]^s[14]^s[12]^s[3]). Widths 8, 24 and 32 use bits {7,5,4,3}, {23,22,21,16} and {31,21,1,0}.
- R2: The seed offered to lane k is seed_i XOR (the low W bits of k × 0x9E3779B9). If that value is all ones, lane k loads 1 in its place. A lane never holds all ones.
- R3: In parallel mode (mode_i=0), each enabled step that is not a load sets word_o bit k to the fresh bit f of lane k and drives valid_o high.
- R4: In serial mode (mode_i=1), each enabled step that is not a load sets word_o to {f of lane 0, word_o[N-1:1]}. After a load, or in parallel mode, a count starts again from 0. valid_o is high only after the step that brings in the N-th bit since that restart, and the count then restarts.
- R5: When en_i and seed_load_i are both high, the lanes load their seeds and do not step, word_o becomes 0, valid_o becomes 0 and the serial count restarts.
- R6: While en_i is low, lane states, word_o and valid_o hold their values, and seed_load_i has no effect.
- R7: Reset (rst_n low, asynchronous) clears word_o and valid_o. Each lane takes the seed it would get from seed_i = 0.
- R8: All lanes step on every enabled cycle that is not a load, in either mode. Parallel words that follow serial operation therefore continue each lane's own sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Step enable; all state holds while low |
| mode_i | input | 1 | 0 = parallel word, 1 = serial assembly from lane 0 |
| seed_load_i | input | 1 | Load lane seeds (acts only while en_i is high) |
| seed_i | input | LFSR_W | External seed value, e.g. a time count |
| word_o | output | N_LANES | Random output word |
| valid_o | output | 1 | Word-ready strobe |

## Verification
A seed load and a generator step can both be requested in the same cycle, and the load must win. The bench raises seed_load_i together with en_i in parallel mode, and again in serial mode when a word is half assembled. After each of these cycles it expects word_o to be zero and valid_o to be low. It also expects the next words to follow a model that starts from the new seeds rather than from a stepped state, and it expects a full eight serial steps before valid_o rises again. A load raised while en_i is low is checked separately: the word and the model sequence must carry on as if no load had been asked for.

// File: rtl/rng_word_pkg.sv
package rng_word_pkg;

  // widest lane supported by the tap table
  localparam int MAX_W = 32;

  // tap positions (bit indices) for the XNOR feedback of each supported width
  function automatic logic [MAX_W-1:0] tap_mask(input int w);
    logic [MAX_W-1:0] m;
    case (w)
      8:       m = 32'h0000_00B8;   // bits 7,5,4,3
      24:      m = 32'h00E1_0000;   // bits 23,22,21,16
      32:      m = 32'h8020_0003;   // bits 31,21,1,0
      default: m = 32'h0000_D008;   // 16: bits 15,14,12,3
    endcase
    return m;
  endfunction

  // fresh bit produced by a lane in state s
  function automatic logic fresh_bit(input logic [MAX_W-1:0] s, input int w);
    return ~(^(s & tap_mask(w)));
  endfunction

  // one step of a lane, newest bit entering at bit 0
  function automatic logic [MAX_W-1:0] lane_next(input logic [MAX_W-1:0] s, input int w);
    logic [MAX_W-1:0] ones;
    ones = MAX_W'((64'd1 << w) - 64'd1);
    return ((s << 1) | MAX_W'(fresh_bit(s, w))) & ones;
  endfunction

  // per-lane constant that spreads the lanes apart
  function automatic logic [MAX_W-1:0] lane_salt(input int k);
    logic [63:0] p;
    p = 64'(k) * 64'h0000_0000_9E37_79B9;
    return p[MAX_W-1:0];
  endfunction

  // the XNOR lockup value is swapped for a legal constant
  function automatic logic [MAX_W-1:0] clean_seed(input logic [MAX_W-1:0] v, input int w);
    logic [MAX_W-1:0] ones;
    ones = MAX_W'((64'd1 << w) - 64'd1);
    return ((v & ones) == ones) ? MAX_W'(1) : (v & ones);
  endfunction

endpackage

// File: rtl/rng_lane.sv
module rng_lane
  import rng_word_pkg::*;
#(
  parameter int W    = 16,
  parameter int LANE = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic         fresh_o
);

  localparam logic [MAX_W-1:0] SALT_WIDE = lane_salt(LANE);
  localparam logic [W-1:0]     SALT      = SALT_WIDE[W-1:0];
  localparam logic [MAX_W-1:0] RST_WIDE  = clean_seed(MAX_W'(SALT), W);
  localparam logic [W-1:0]     RST_SEED  = RST_WIDE[W-1:0];

  logic [W-1:0]     state_q;
  logic [W-1:0]     seed_mix;
  logic [MAX_W-1:0] seed_clean_w;
  logic [W-1:0]     seed_clean;
  logic [MAX_W-1:0] next_w;
  logic [W-1:0]     state_next;

  assign seed_mix     = seed_i ^ SALT;
  assign seed_clean_w = clean_seed(MAX_W'(seed_mix), W);
  assign seed_clean   = seed_clean_w[W-1:0];
  assign next_w       = lane_next(MAX_W'(state_q), W);
  assign state_next   = next_w[W-1:0];
  assign fresh_o      = fresh_bit(MAX_W'(state_q), W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= RST_SEED;
    else if (load_i) state_q <= seed_clean;
    else if (step_i) state_q <= state_next;
  end

  // R2
  no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != {W{1'b1}});

  // R1
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (state_q[W-1:1] == $past(state_q[W-2:0])));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (state_q == $past(seed_clean)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(state_q));

endmodule

// File: rtl/rng_assembler.sv
module rng_assembler #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         mode_i,
  input  logic         load_i,
  input  logic [N-1:0] fresh_i,
  output logic [N-1:0] word_o,
  output logic         valid_o
);

  localparam int              CNT_W = $clog2(N + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  // top insertion: y = b*2^(N-1) + floor(y/2)
  function automatic logic [N-1:0] insert_top(input logic [N-1:0] y, input logic b);
    return {b, y[N-1:1]};
  endfunction

  logic [N-1:0]     word_q;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;

  // named events
  logic ev_load, ev_par, ev_ser, ev_full;
  assign ev_load = en_i & load_i;
  assign ev_par  = en_i & ~load_i & ~mode_i;
  assign ev_ser  = en_i & ~load_i &  mode_i;
  assign ev_full = ev_ser & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (ev_load) begin
      word_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (ev_par) begin
      word_q  <= fresh_i;
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (ev_ser) begin
      word_q  <= insert_top(word_q, fresh_i[0]);
      cnt_q   <= ev_full ? '0 : cnt_q + 1'b1;
      valid_q <= ev_full;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R4
  serial_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ser |=> (word_q[N-2:0] == $past(word_q[N-1:1])));

  // R3
  par_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_par |=> valid_q);

  // R4
  ser_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ser && cnt_q != LAST) |=> !valid_q);

  // R5
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (word_q == '0 && !valid_q && cnt_q == '0));

  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(word_q) && $stable(valid_q) && $stable(cnt_q)));

endmodule

// File: rtl/rng_word_gen.sv
module rng_word_gen #(
  parameter int N_LANES = 8,
  parameter int LFSR_W  = 16   // 8, 16, 24 or 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [N_LANES-1:0] word_o,
  output logic              valid_o
);

  logic               lane_step;
  logic               lane_load;
  logic [N_LANES-1:0] fresh;

  // R8: every lane steps on every enabled non-load cycle
  assign lane_step = en_i & ~seed_load_i;
  assign lane_load = en_i &  seed_load_i;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    rng_lane #(
      .W    (LFSR_W),
      .LANE (k)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (lane_step),
      .load_i  (lane_load),
      .seed_i  (seed_i),
      .fresh_o (fresh[k])
    );
  end

  rng_assembler #(
    .N (N_LANES)
  ) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .mode_i  (mode_i),
    .load_i  (seed_load_i),
    .fresh_i (fresh),
    .word_o  (word_o),
    .valid_o (valid_o)
  );

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (word_o == '0 && !valid_o));

endmodule

// File: tb/sim_rng_word_gen.sv
`timescale 1ns/1ps
module sim_rng_word_gen;

  localparam int N = 8;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en_i = 1'b0;
  logic         mode_i = 1'b0;
  logic         seed_load_i = 1'b0;
  logic [W-1:0] seed_i = '0;
  logic [N-1:0] word_o;
  logic         valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rng_word_gen #(.N_LANES(N), .LFSR_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
    .seed_load_i(seed_load_i), .seed_i(seed_i),
    .word_o(word_o), .valid_o(valid_o)
  );

  // ---------------- reference model, written from the requirements
  logic [W-1:0] m_lane [N];
  logic [N-1:0] m_word;
  logic         m_valid;
  int           m_cnt;

  function automatic logic [W-1:0] b_salt(input int k);
    logic [63:0] p;
    p = 64'(k) * 64'h9E3779B9;
    return p[W-1:0];
  endfunction

  function automatic logic [W-1:0] b_clean(input logic [W-1:0] v);
    if (v == 16'hFFFF) return 16'h0001;
    return v;
  endfunction

  function automatic logic b_new(input logic [W-1:0] s);
    return !(s[15] ^ s[14] ^ s[12] ^ s[3]);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < N; k++) m_lane[k] = b_clean(b_salt(k));
    m_word = '0; m_valid = 1'b0; m_cnt = 0;
  endtask

  task automatic model_clock(input logic e, input logic m, input logic l, input logic [W-1:0] s);
    logic [N-1:0] f;
    for (int k = 0; k < N; k++) f[k] = b_new(m_lane[k]);
    if (!e) return;
    if (l) begin
      for (int k = 0; k < N; k++) m_lane[k] = b_clean(s ^ b_salt(k));
      m_word = '0; m_valid = 1'b0; m_cnt = 0;
      return;
    end
    for (int k = 0; k < N; k++) m_lane[k] = {m_lane[k][W-2:0], f[k]};
    if (!m) begin
      m_word = f; m_valid = 1'b1; m_cnt = 0;
    end else begin
      m_word = {f[0], m_word[N-1:1]};
      m_cnt++;
      m_valid = (m_cnt == N);
      if (m_cnt == N) m_cnt = 0;
    end
  endtask

  task automatic check(input string req, input logic [N-1:0] w_exp, input logic v_exp);
    checks++;
    if (word_o !== w_exp || valid_o !== v_exp) begin
      fails++;
      $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b",
               req, word_o, valid_o, w_exp, v_exp);
    end
  endtask

  // drive after a falling edge, clock, update the model, compare at the next falling edge
  task automatic cycle(input logic e, input logic m, input logic l, input logic [W-1:0] s, input string req);
    en_i = e; mode_i = m; seed_load_i = l; seed_i = s;
    @(posedge clk);
    model_clock(e, m, l, s);
    @(negedge clk);
    check(req, m_word, m_valid);
  endtask

  // vector: {req_index[3:0], en, mode, load, seed[15:0]}
  localparam int NV = 34;
  localparam logic [22:0] VEC [NV] = '{
    {4'd3, 1'b1, 1'b0, 1'b0, 16'h0000},   // R3 parallel from reset seeds (R7)
    {4'd3, 1'b1, 1'b0, 1'b0, 16'h0000},
    {4'd3, 1'b1, 1'b0, 1'b0, 16'h0000},
    {4'd5, 1'b1, 1'b0, 1'b1, 16'hACE1},   // R5 load beats step
    {4'd3, 1'b1, 1'b0, 1'b0, 16'h0000},
    {4'd3, 1'b1, 1'b0, 1'b0, 16'h0000},
    {4'd6, 1'b0, 1'b0, 1'b0, 16'h0000},   // R6 frozen
    {4'd6, 1'b0, 1'b0, 1'b1, 16'h1234},   // R6 load ignored while frozen
    {4'd3, 1'b1, 1'b0, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},   // R4 serial assembly
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd6, 1'b0, 1'b1, 1'b0, 16'h0000},   // R6 freeze mid-word
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},   // eighth bit: valid
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd5, 1'b1, 1'b1, 1'b1, 16'hBEEF},   // R5 load mid serial word
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},   // eighth since load: valid
    {4'd8, 1'b1, 1'b0, 1'b0, 16'h0000},   // R8 back to parallel
    {4'd8, 1'b1, 1'b0, 1'b0, 16'h0000},
    {4'd4, 1'b1, 1'b1, 1'b0, 16'h0000},   // R4 count restarted by parallel
    {4'd1, 1'b1, 1'b0, 1'b0, 16'h0000}    // R1 sequence continues
  };

  function automatic string req_name(input int i);
    case (i)
      1: return "R1"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 8: return "R8"; default: return "R7";
    endcase
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", '0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0], req_name(int'(VEC[i][22:19])));
    end

    // R2: seed that would put lane 3 into the all-ones state
    cycle(1'b1, 1'b0, 1'b1, ~b_salt(3), "R2");
    for (int i = 0; i < 24; i++) cycle(1'b1, 1'b0, 1'b0, '0, "R2");

    // R4: check that serial output is the top-inserted history of lane 0
    cycle(1'b1, 1'b1, 1'b1, 16'h0F0F, "R5");
    for (int i = 0; i < 16; i++) cycle(1'b1, 1'b1, 1'b0, '0, "R4");

    // R1: long parallel run against the model
    for (int i = 0; i < 200; i++) cycle(1'b1, 1'b0, 1'b0, '0, "R1");

    // R7: reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    check("R7", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b1, 1'b0, 1'b0, '0, "R7");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule